// File: doc/BRIEF.md
# Predicated Vector Integer-to-Float Converter

This block executes one vector conversion instruction. It takes a 32-bit instruction word, a source vector holding integer lanes, the previous contents of the destination vector and a per-byte predicate. For every active lane it converts a signed or unsigned integer into an IEEE 754 half, single or double precision value, rounding to nearest with ties to even. Lanes that are not active keep their previous destination value. The merged vector, the exception flags and an illegal-encoding indication appear one clock after the instruction is presented.

The instruction word selects the lane width, the integer width and the result format. Seven combinations are legal. Half-precision results report exceptions through their own flag pair. Single and double results report through a second pair. Each pair has its own enable input. The caller supplies the predicate that has already been read out from the predicate register, and the caller writes the result back. The register-number fields of the word are therefore not used here.

Top module: `vcvt_i2f`

## Requirements
- R1: The word is accepted only when bits 31:24 are 01100101, bits 21:19 are 010 and bits 15:13 are 101, and {bits 23:22, bits 18:17} is one of 0101, 0110, 0111, 1010, 1100, 1110, 1111. These map in order to: 16-bit int to half in 16-bit lanes; 32-bit int to half in 32-bit lanes; 64-bit int to half in 64-bit lanes; 32-bit int to single in 32-bit lanes; 32-bit int to double in 64-bit lanes; 64-bit int to single in 64-bit lanes; 64-bit int to double in 64-bit lanes. Any other word raises `illegal`, returns `old_vec` unchanged and raises no flags.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. When `in_valid` is low, `res_vec`, the flags and `illegal` hold their values.
- R3: Lane i of width W bits is active when `pred[i*W/8]` is 1. The predicate bits of the lane's other bytes have no effect.
- R4: An inactive lane returns its `old_vec` bits unchanged and contributes no flags.
- R5: Bit 16 of the word selects the integer type: 0 means two's-complement signed, 1 means unsigned. The sign of the result is the integer's sign bit.
- R6: Results are rounded to nearest, ties to even. The inexact flag (flag bit 0) is raised when any discarded bit is nonzero.
- R7: A half-precision result whose rounded magnitude exceeds 65504 becomes infinity (0x7C00 or 0xFC00) with overflow (flag bit 1) and inexact both set. Only half-precision forms can overflow.
- R8: In the 32-bit-to-double form, only the low 32 bits of each 64-bit lane are converted.
- R9: A result narrower than its lane sits in the lane's low bits, and the lane's upper bits are zero.
- R10: Half-precision forms report in `hp_flags` only, and only while `hp_flag_en` is 1. Single and double forms report in `sp_flags` only, and only while `sp_flag_en` is 1. Each pair is the OR over the active lanes.
- R11: An integer zero converts to +0.0 and raises no flag.
- R12: After reset, `out_valid`, `res_vec`, both flag pairs and `illegal` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction and operands present this cycle |
| instr | input | 32 | Instruction word |
| src_vec | input | VLEN | Integer source vector |
| old_vec | input | VLEN | Previous destination contents |
| pred | input | VLEN/8 | Governing predicate, one bit per byte |
| hp_flag_en | input | 1 | Enables flag reporting for half-precision forms |
| sp_flag_en | input | 1 | Enables flag reporting for single/double forms |
| out_valid | output | 1 | Result present |
| res_vec | output | VLEN | Merged result vector |
| hp_flags | output | 2 | Half-precision flags {overflow, inexact} |
| sp_flags | output | 2 | Single/double flags {overflow, inexact} |
| illegal | output | 1 | Instruction word not a legal form |

## Verification
The only state is one output register, so a fault in the decode or in a lane converter shows up in the result cycle of the instruction that caused it. It appears as a wrong lane pattern in `res_vec`, as flags in the wrong pair, or as an `illegal` value that disagrees with the word. A hold register that fails to hold becomes visible one cycle later, when `res_vec` or the flags change during an idle cycle. The bench's model is compared with the outputs on every clock, so any of these faults is reported in the cycle where it first appears.

// File: rtl/vcvt_i2f_pkg.sv
package vcvt_i2f_pkg;

    typedef enum logic [1:0] {
        FMT_HALF   = 2'd0,
        FMT_SINGLE = 2'd1,
        FMT_DOUBLE = 2'd2
    } fp_fmt_e;

    typedef enum logic [1:0] {
        LANE_16 = 2'd0,
        LANE_32 = 2'd1,
        LANE_64 = 2'd2
    } lane_sz_e;

    localparam int HALF_MW   = 10;
    localparam int HALF_EW   = 5;
    localparam int HALF_BIAS = 15;
    localparam int SGL_MW    = 23;
    localparam int SGL_EW    = 8;
    localparam int SGL_BIAS  = 127;
    localparam int DBL_MW    = 52;
    localparam int DBL_EW    = 11;
    localparam int DBL_BIAS  = 1023;

    // norm: magnitude with its leading one at bit 63; expo: position of that one.
    // Returns {overflow, inexact, encoding right-aligned in 64 bits}.
    function automatic logic [65:0] round_pack(
        input logic [63:0] norm,
        input logic [6:0]  expo,
        input logic        sgn,
        input int          mw,
        input int          ew,
        input int          bias
    );
        logic [63:0] kept;
        logic [63:0] rem_mask;
        logic [63:0] frac;
        logic [63:0] bits;
        logic [64:0] sum;
        logic        guard;
        logic        sticky;
        logic        rup;
        logic        ovf;
        int          bexp;
        kept     = norm >> (63 - mw);
        guard    = norm[62 - mw];
        rem_mask = (64'd1 << (62 - mw)) - 64'd1;
        sticky   = |(norm & rem_mask);
        rup      = guard & (sticky | kept[0]);
        sum      = {1'b0, kept} + {64'd0, rup};
        bexp     = int'(expo) + bias;
        if (sum[mw + 1]) begin
            bexp = bexp + 1;
            frac = 64'd0;
        end else begin
            frac = sum[63:0] & ((64'd1 << mw) - 64'd1);
        end
        ovf = (bexp >= ((1 << ew) - 1));
        if (ovf) begin
            bits = ({63'd0, sgn} << (mw + ew)) | (((64'd1 << ew) - 64'd1) << mw);
        end else begin
            bits = ({63'd0, sgn} << (mw + ew)) | (64'(bexp) << mw) | frac;
        end
        return {ovf, (guard | sticky | ovf), bits};
    endfunction

endpackage

// File: rtl/vcvt_i2f_lzc.sv
module vcvt_i2f_lzc #(
    parameter int W = 64,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  val,
    output logic [CW-1:0] cnt
);

    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (val[i]) begin
                cnt = CW'(W - 1 - i);
            end
        end
    end

endmodule

// File: rtl/vcvt_i2f_lane.sv
module vcvt_i2f_lane
    import vcvt_i2f_pkg::*;
#(
    parameter int IW = 64
) (
    input  logic [IW-1:0] raw,
    input  logic          is_signed,
    input  fp_fmt_e       fmt,
    output logic [IW-1:0] res,
    output logic          ovf,
    output logic          inx
);

    localparam int LZW = $clog2(IW + 1);

    logic          neg;
    logic [IW-1:0] mag;
    logic [LZW-1:0] lz;
    logic [63:0]   norm;
    logic [6:0]    expo;
    logic [65:0]   pk;

    assign neg = is_signed & raw[IW-1];
    assign mag = neg ? (~raw + IW'(1)) : raw;

    vcvt_i2f_lzc #(.W(IW)) u_lzc (
        .val (mag),
        .cnt (lz)
    );

    assign norm = (64'(mag) << (64 - IW)) << lz;
    assign expo = 7'(IW - 1) - 7'(lz);

    always_comb begin
        if (mag == '0) begin
            pk = '0;
        end else begin
            case (fmt)
                FMT_SINGLE: pk = round_pack(norm, expo, neg, SGL_MW, SGL_EW, SGL_BIAS);
                FMT_DOUBLE: pk = round_pack(norm, expo, neg, DBL_MW, DBL_EW, DBL_BIAS);
                default:    pk = round_pack(norm, expo, neg, HALF_MW, HALF_EW, HALF_BIAS);
            endcase
        end
    end

    assign res = pk[IW-1:0];
    assign ovf = pk[65];
    assign inx = pk[64];

    if (IW < 64) begin : g_hi
        logic unused_hi;
        assign unused_hi = ^pk[63:IW];
    end

endmodule

// File: rtl/vcvt_i2f_bank.sv
module vcvt_i2f_bank
    import vcvt_i2f_pkg::*;
#(
    parameter int VLEN = 256,
    parameter int LW   = 16,
    localparam int NL  = VLEN / LW,
    localparam int BPL = LW / 8
) (
    input  logic [VLEN-1:0]   src,
    input  logic [VLEN-1:0]   old,
    input  logic [VLEN/8-1:0] pred,
    input  logic              is_signed,
    input  fp_fmt_e           fmt,
    output logic [VLEN-1:0]   merged,
    output logic              ovf_any,
    output logic              inx_any
);

    logic [NL-1:0] act;
    logic [NL-1:0] l_ovf;
    logic [NL-1:0] l_inx;
    logic          unused_pred;

    assign unused_pred = ^pred;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic [LW-1:0] l_res;

        vcvt_i2f_lane #(.IW(LW)) u_lane (
            .raw       (src[i*LW +: LW]),
            .is_signed (is_signed),
            .fmt       (fmt),
            .res       (l_res),
            .ovf       (l_ovf[i]),
            .inx       (l_inx[i])
        );

        assign act[i] = pred[i*BPL];
        assign merged[i*LW +: LW] = act[i] ? l_res : old[i*LW +: LW];
    end

    assign ovf_any = |(l_ovf & act);
    assign inx_any = |(l_inx & act);

endmodule

// File: rtl/vcvt_i2f.sv
module vcvt_i2f
    import vcvt_i2f_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic [VLEN-1:0]   src_vec,
    input  logic [VLEN-1:0]   old_vec,
    input  logic [VLEN/8-1:0] pred,
    input  logic              hp_flag_en,
    input  logic              sp_flag_en,
    output logic              out_valid,
    output logic [VLEN-1:0]   res_vec,
    output logic [1:0]        hp_flags,
    output logic [1:0]        sp_flags,
    output logic              illegal
);

    localparam int NG64 = VLEN / 64;

    typedef struct packed {
        logic     legal;
        logic     is_signed;
        logic     narrow;
        lane_sz_e lsz;
        fp_fmt_e  fmt;
    } dec_t;

    typedef struct packed {
        logic            vld;
        logic [VLEN-1:0] res;
        logic [1:0]      hpf;
        logic [1:0]      spf;
        logic            ill;
    } state_t;

    dec_t            dec;
    state_t          st_d, st_q;
    logic            fixed_ok;
    logic            unused_fields;
    logic [VLEN-1:0] src64;
    logic [VLEN-1:0] m16, m32, m64;
    logic            o16, o32, o64;
    logic            x16, x32, x64;
    logic [VLEN-1:0] sel_res;
    logic            sel_ovf;
    logic            sel_inx;

    // Register-number fields are consumed by the caller.
    assign unused_fields = ^instr[12:0];

    assign fixed_ok = (instr[31:24] == 8'b0110_0101) &&
                      (instr[21:19] == 3'b010) &&
                      (instr[15:13] == 3'b101);

    always_comb begin
        dec           = '0;
        dec.is_signed = ~instr[16];
        dec.legal     = 1'b1;
        dec.lsz       = LANE_16;
        dec.fmt       = FMT_HALF;
        case ({instr[23:22], instr[18:17]})
            4'b0101: begin dec.lsz = LANE_16; dec.fmt = FMT_HALF;   end
            4'b0110: begin dec.lsz = LANE_32; dec.fmt = FMT_HALF;   end
            4'b0111: begin dec.lsz = LANE_64; dec.fmt = FMT_HALF;   end
            4'b1010: begin dec.lsz = LANE_32; dec.fmt = FMT_SINGLE; end
            4'b1100: begin dec.lsz = LANE_64; dec.fmt = FMT_DOUBLE; dec.narrow = 1'b1; end
            4'b1110: begin dec.lsz = LANE_64; dec.fmt = FMT_SINGLE; end
            4'b1111: begin dec.lsz = LANE_64; dec.fmt = FMT_DOUBLE; end
            default: dec.legal = 1'b0;
        endcase
        if (!fixed_ok) begin
            dec.legal = 1'b0;
        end
    end

    // 32-bit sources in 64-bit lanes: extend the low word before conversion.
    for (genvar k = 0; k < NG64; k++) begin : g_ext
        assign src64[k*64 +: 64] = dec.narrow
            ? {{32{dec.is_signed & src_vec[k*64 + 31]}}, src_vec[k*64 +: 32]}
            : src_vec[k*64 +: 64];
    end

    vcvt_i2f_bank #(.VLEN(VLEN), .LW(16)) u_bank16 (
        .src (src_vec), .old (old_vec), .pred (pred),
        .is_signed (dec.is_signed), .fmt (dec.fmt),
        .merged (m16), .ovf_any (o16), .inx_any (x16)
    );

    vcvt_i2f_bank #(.VLEN(VLEN), .LW(32)) u_bank32 (
        .src (src_vec), .old (old_vec), .pred (pred),
        .is_signed (dec.is_signed), .fmt (dec.fmt),
        .merged (m32), .ovf_any (o32), .inx_any (x32)
    );

    vcvt_i2f_bank #(.VLEN(VLEN), .LW(64)) u_bank64 (
        .src (src64), .old (old_vec), .pred (pred),
        .is_signed (dec.is_signed), .fmt (dec.fmt),
        .merged (m64), .ovf_any (o64), .inx_any (x64)
    );

    always_comb begin
        case (dec.lsz)
            LANE_32: begin sel_res = m32; sel_ovf = o32; sel_inx = x32; end
            LANE_64: begin sel_res = m64; sel_ovf = o64; sel_inx = x64; end
            default: begin sel_res = m16; sel_ovf = o16; sel_inx = x16; end
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (in_valid) begin
            st_d.vld = 1'b1;
            st_d.ill = ~dec.legal;
            st_d.hpf = 2'b00;
            st_d.spf = 2'b00;
            if (dec.legal) begin
                st_d.res = sel_res;
                if (dec.fmt == FMT_HALF) begin
                    st_d.hpf = hp_flag_en ? {sel_ovf, sel_inx} : 2'b00;
                end else begin
                    st_d.spf = sp_flag_en ? {sel_ovf, sel_inx} : 2'b00;
                end
            end else begin
                st_d.res = old_vec;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign res_vec   = st_q.res;
    assign hp_flags  = st_q.hpf;
    assign sp_flags  = st_q.spf;
    assign illegal   = st_q.ill;

endmodule

// File: rtl/vcvt_i2f_chk.sv
module vcvt_i2f_chk #(
    parameter int VLEN = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [VLEN-1:0]   old_vec,
    input logic [VLEN/8-1:0] pred,
    input logic              out_valid,
    input logic [VLEN-1:0]   res_vec,
    input logic [1:0]        hp_flags,
    input logic [1:0]        sp_flags,
    input logic              illegal
);

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid) |-> out_valid);

    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> !out_valid);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> ($stable(res_vec) && $stable(hp_flags) && $stable(sp_flags) && $stable(illegal)));

    assert_illegal_keeps_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && illegal) |-> (res_vec == $past(old_vec) && hp_flags == 2'b00 && sp_flags == 2'b00));

    assert_no_pred_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) && $past(pred) == '0) |-> (res_vec == $past(old_vec) && hp_flags == 2'b00 && sp_flags == 2'b00));

    assert_one_flag_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !((|hp_flags) && (|sp_flags)));

    assert_ovf_implies_inx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hp_flags[1] |-> hp_flags[0]);

    assert_no_wide_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !sp_flags[1]);

endmodule

bind vcvt_i2f vcvt_i2f_chk #(.VLEN(VLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .old_vec   (old_vec),
    .pred      (pred),
    .out_valid (out_valid),
    .res_vec   (res_vec),
    .hp_flags  (hp_flags),
    .sp_flags  (sp_flags),
    .illegal   (illegal)
);

// File: tb/vcvt_i2f_bench.sv
module vcvt_i2f_bench;

    localparam int VLEN       = 256;
    localparam int PW         = VLEN / 8;
    localparam int CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [31:0]     instr = '0;
    logic [VLEN-1:0] src_vec = '0;
    logic [VLEN-1:0] old_vec = '0;
    logic [PW-1:0]   pred = '0;
    logic            hp_flag_en = 1'b0;
    logic            sp_flag_en = 1'b0;
    logic            out_valid;
    logic [VLEN-1:0] res_vec;
    logic [1:0]      hp_flags;
    logic [1:0]      sp_flags;
    logic            illegal;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic            exp_vld = 1'b0;
    logic [VLEN-1:0] exp_res = '0;
    logic [1:0]      exp_hp = '0;
    logic [1:0]      exp_sp = '0;
    logic            exp_ill = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vcvt_i2f #(.VLEN(VLEN)) u_vcvt_i2f (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .instr (instr),
        .src_vec (src_vec), .old_vec (old_vec), .pred (pred),
        .hp_flag_en (hp_flag_en), .sp_flag_en (sp_flag_en),
        .out_valid (out_valid), .res_vec (res_vec), .hp_flags (hp_flags),
        .sp_flags (sp_flags), .illegal (illegal)
    );

    task automatic check(input string tag, input string what,
                         input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "out_valid", VLEN'(out_valid), VLEN'(exp_vld));
        check(tag, "res_vec",   res_vec,          exp_res);
        check(tag, "hp_flags",  VLEN'(hp_flags),  VLEN'(exp_hp));
        check(tag, "sp_flags",  VLEN'(sp_flags),  VLEN'(exp_sp));
        check(tag, "illegal",   VLEN'(illegal),   VLEN'(exp_ill));
    endtask

    function automatic logic [31:0] mk(input logic [1:0] sz, input logic [1:0] opc, input bit uns);
        return {8'b0110_0101, sz, 3'b010, opc, uns, 3'b101, 13'($urandom)};
    endfunction

    function automatic longint unsigned wmask(input int w);
        return (w >= 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    endfunction

    // Behavioural integer-to-float: remainder compared with half an ulp.
    task automatic ref_cvt(input longint unsigned raw_in, input int iw, input bit sgn,
                           input int mw, input int ew, input int bias,
                           output longint unsigned bits, output bit ovf, output bit inx);
        longint unsigned raw, mag, q, r, half;
        int p, sh;
        bit neg;
        raw  = raw_in & wmask(iw);
        neg  = sgn && raw[iw-1];
        mag  = neg ? ((~raw + 64'd1) & wmask(iw)) : raw;
        bits = 0; ovf = 0; inx = 0;
        if (mag == 0) return;
        p = 63;
        while (mag[p] == 1'b0) p--;
        if (p <= mw) begin
            q = mag << (mw - p);
        end else begin
            sh   = p - mw;
            q    = mag >> sh;
            r    = mag - (q << sh);
            half = 64'd1 << (sh - 1);
            inx  = (r != 0);
            if (r > half || (r == half && q[0])) q++;
            if (q == (64'd1 << (mw + 1))) begin
                q = q >> 1;
                p++;
            end
        end
        if (p + bias >= (1 << ew) - 1) begin
            ovf  = 1; inx = 1;
            bits = (64'(neg) << (mw + ew)) | (64'((1 << ew) - 1) << mw);
            return;
        end
        bits = (64'(neg) << (mw + ew)) | (64'(p + bias) << mw) | (q & wmask(mw));
    endtask

    task automatic model_issue(input logic [31:0] ins, input logic [VLEN-1:0] s,
                               input logic [VLEN-1:0] o, input logic [PW-1:0] p,
                               input bit hpen, input bit spen);
        bit legal, is_hp, ovf_any, inx_any;
        int lw, iw, mw, ew, bias;
        legal = (ins[31:24] == 8'b0110_0101) && (ins[21:19] == 3'b010) && (ins[15:13] == 3'b101);
        is_hp = 0; lw = 16; iw = 16; mw = 10; ew = 5; bias = 15;
        case ({ins[23:22], ins[18:17]})
            4'b0101: begin lw = 16; iw = 16; is_hp = 1; end
            4'b0110: begin lw = 32; iw = 32; is_hp = 1; end
            4'b0111: begin lw = 64; iw = 64; is_hp = 1; end
            4'b1010: begin lw = 32; iw = 32; mw = 23; ew = 8;  bias = 127;  end
            4'b1100: begin lw = 64; iw = 32; mw = 52; ew = 11; bias = 1023; end
            4'b1110: begin lw = 64; iw = 64; mw = 23; ew = 8;  bias = 127;  end
            4'b1111: begin lw = 64; iw = 64; mw = 52; ew = 11; bias = 1023; end
            default: legal = 0;
        endcase
        ovf_any = 0; inx_any = 0;
        exp_vld = 1'b1; exp_hp = 2'b00; exp_sp = 2'b00; exp_ill = !legal; exp_res = o;
        if (legal) begin
            for (int i = 0; i < VLEN / lw; i++) begin
                if (p[i*lw/8]) begin
                    longint unsigned raw, bits;
                    logic [VLEN-1:0] lmask;
                    bit ov, ix;
                    raw = 64'(s >> (i*lw));
                    ref_cvt(raw, iw, !ins[16], mw, ew, bias, bits, ov, ix);
                    lmask   = VLEN'(wmask(lw)) << (i*lw);
                    exp_res = (exp_res & ~lmask) | (VLEN'(bits) << (i*lw));
                    ovf_any |= ov;
                    inx_any |= ix;
                end
            end
            if (is_hp) exp_hp = hpen ? {ovf_any, inx_any} : 2'b00;
            else       exp_sp = spen ? {ovf_any, inx_any} : 2'b00;
        end
    endtask

    task automatic issue(input logic [31:0] ins, input logic [VLEN-1:0] s,
                         input logic [VLEN-1:0] o, input logic [PW-1:0] p,
                         input bit hpen, input bit spen, input string tag);
        in_valid = 1'b1; instr = ins; src_vec = s; old_vec = o; pred = p;
        hp_flag_en = hpen; sp_flag_en = spen;
        model_issue(ins, s, o, p, hpen, spen);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic idle(input string tag);
        in_valid = 1'b0;
        src_vec  = rand_vec();
        old_vec  = rand_vec();
        exp_vld  = 1'b0;
        @(negedge clk);
        compare_all(tag);
    endtask

    function automatic logic [VLEN-1:0] rand_vec();
        logic [VLEN-1:0] v;
        for (int k = 0; k < VLEN/32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [VLEN-1:0] put(input logic [VLEN-1:0] v, input int lw,
                                            input int i, input longint unsigned val);
        return (v & ~(VLEN'(wmask(lw)) << (i*lw))) | (VLEN'(val & wmask(lw)) << (i*lw));
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [VLEN-1:0] s, o;
        logic [3:0] codes [7] = '{4'b0101, 4'b0110, 4'b0111, 4'b1010, 4'b1100, 4'b1110, 4'b1111};

        // R12: reset state
        repeat (3) begin
            @(negedge clk);
            compare_all("R12");
        end
        rst_n = 1'b1;
        idle("R12");

        // 16-bit unsigned to half: overflow, zero, exact max, ties
        o = rand_vec();
        s = '0;
        s = put(s, 16, 0, 65535);
        s = put(s, 16, 1, 0);
        s = put(s, 16, 2, 65504);
        s = put(s, 16, 3, 2049);
        s = put(s, 16, 4, 2051);
        s = put(s, 16, 5, 1);
        issue(mk(2'b01, 2'b01, 1), s, o, '1, 1, 1, "R7");
        check("R7",  "lane0", VLEN'(res_vec[15:0]),  VLEN'(16'h7C00));
        check("R11", "lane1", VLEN'(res_vec[31:16]), VLEN'(16'h0000));
        check("R6",  "lane3 tie even", VLEN'(res_vec[63:48]), VLEN'(16'h6800));
        check("R6",  "lane4 tie odd",  VLEN'(res_vec[79:64]), VLEN'(16'h6802));
        check("R7",  "hp flags", VLEN'(hp_flags), VLEN'(2'b11));

        // Same data signed: 0xFFFF is -1
        issue(mk(2'b01, 2'b01, 0), s, o, '1, 1, 1, "R5");
        check("R5", "lane0 -1", VLEN'(res_vec[15:0]), VLEN'(16'hBC00));
        check("R5", "lane5 +1", VLEN'(res_vec[95:80]), VLEN'(16'h3C00));

        // Flags disabled: values still written, no flags
        issue(mk(2'b01, 2'b01, 1), s, o, '1, 0, 1, "R10");

        // 32-bit lanes to half: only non-lowest predicate bytes set -> all inactive
        s = '0;
        for (int i = 0; i < VLEN/32; i++) s = put(s, 32, i, 1);
        issue(mk(2'b01, 2'b10, 0), s, o, {(PW/4){4'b1110}}, 1, 1, "R3");
        check("R3", "untouched", res_vec, o);
        issue(mk(2'b01, 2'b10, 0), s, o, {(PW/4){4'b0001}}, 1, 1, "R9");
        check("R9", "lane0 hp in 32", VLEN'(res_vec[31:0]), VLEN'(32'h0000_3C00));

        // 32-bit to single, rounding up to 2^32
        s = '0;
        s = put(s, 32, 0, 64'hFFFF_FFFF);
        issue(mk(2'b10, 2'b10, 1), s, o, '1, 1, 1, "R6");
        check("R6", "2^32 single", VLEN'(res_vec[31:0]), VLEN'(32'h4F80_0000));
        check("R10", "sp inexact", VLEN'(sp_flags), VLEN'(2'b01));
        check("R10", "hp quiet", VLEN'(hp_flags), VLEN'(2'b00));

        // 32-bit to double with garbage in the upper half
        s = '0;
        s = put(s, 64, 0, 64'hDEAD_BEEF_0000_0001);
        s = put(s, 64, 1, 64'h1234_5678_FFFF_FFFF);
        issue(mk(2'b11, 2'b00, 0), s, o, '1, 1, 1, "R8");
        check("R8", "lane0 1.0", VLEN'(res_vec[63:0]), VLEN'(64'h3FF0_0000_0000_0000));
        check("R8", "lane1 -1.0", VLEN'(res_vec[127:64]), VLEN'(64'hBFF0_0000_0000_0000));

        // 64-bit forms with extremes
        s = '0;
        s = put(s, 64, 0, 64'h8000_0000_0000_0000);
        s = put(s, 64, 1, 64'h7FFF_FFFF_FFFF_FFFF);
        s = put(s, 64, 2, 64'hFFFF_FFFF_FFFF_FFFF);
        for (int u = 0; u < 2; u++) begin
            issue(mk(2'b11, 2'b11, u[0]), s, o, '1, 1, 1, "R6");
            issue(mk(2'b11, 2'b10, u[0]), s, o, '1, 1, 1, "R9");
            issue(mk(2'b01, 2'b11, u[0]), s, o, '1, 1, 1, "R7");
        end

        // Illegal encodings
        issue(mk(2'b10, 2'b00, 0), s, o, '1, 1, 1, "R1");
        check("R1", "illegal pair", VLEN'(illegal), VLEN'(1'b1));
        issue(mk(2'b11, 2'b11, 0) ^ 32'h0010_0000, s, o, '1, 1, 1, "R1");
        check("R1", "bad fixed field", res_vec, o);

        // No active lanes
        issue(mk(2'b11, 2'b11, 0), s, o, '0, 1, 1, "R4");

        // Hold while idle
        idle("R2");
        idle("R2");

        // Randomised mix, back-to-back and with gaps
        for (int n = 0; n < 400; n++) begin
            logic [31:0] ins;
            logic [PW-1:0] p;
            logic [3:0] c;
            c   = codes[$urandom % 7];
            ins = mk(c[3:2], c[1:0], $urandom % 2);
            if ($urandom % 10 == 0) ins = mk(2'($urandom), 2'($urandom), $urandom % 2);
            if ($urandom % 20 == 0) ins = ins ^ (32'd1 << ($urandom % 19 + 13));
            s = rand_vec();
            if ($urandom % 3 == 0) s = s & {(VLEN/32){32'h0000_FFFF}};
            if ($urandom % 4 == 0) s = s | {(VLEN/32){32'h8000_0000}};
            p = PW'(rand_vec());
            if ($urandom % 5 == 0) p = '1;
            issue(ins, s, rand_vec(), p, 1'($urandom), 1'($urandom), "R4");
            if ($urandom % 4 == 0) idle("R2");
        end
        idle("R2");

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule